// File: doc/BRIEF.md
# Dual Programmable Interval Timer

Two identical down-counters sit behind a 32-bit synchronous register port. Software sets a reload value (divisor) for each timer. It then writes a control word that combines an operation with a tick-source code. The operation loads the divisor into the counter, freezes the counter, or lets it run. While a timer runs it counts down once per strobe from its selected tick source. When it expires it reloads itself from its divisor, so the timer is periodic.

Each expiry latches a bit in a shared raw interrupt vector. A mask register gates that vector into a masked status word and a single interrupt line. An acknowledge register clears the bits written as 1. Tick sources come in as single-cycle enable strobes, since clock generation lives elsewhere.

The port is word-addressed. Timer i uses addresses 3i (divisor), 3i+1 (control) and 3i+2 (live count). After the timers come the mask, the acknowledge register and the masked status.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both control registers read 5 (hold, tick source 1), both counts and the divisor registers read 0, the mask and the masked status read 0, and `irq_o` is low.
- R2: Writing a control word with operation field [1:0] = 0 (load) copies the divisor into the counter at that write. In load mode the counter ignores ticks.
- R3: With operation 1 (hold) the counter keeps its value whatever strobes arrive.
- R4: With operation 2 (run), each strobe of the selected source decrements the counter. A strobe that finds the counter at 0 reloads it from the divisor and marks an expiry, which gives a period of divisor+1 strobes.
- R5: A control write whose operation field is 3 is dropped. The control register and the counter keep their values.
- R6: Control field [4:2] selects the tick source. Code 0 selects `ext_tick_i`, codes 4 to 7 select `tick_i[0]` to `tick_i[3]`, and codes 1, 2 and 3 select nothing, so the timer never advances. Strobes on unselected inputs have no effect.
- R7: An expiry of timer i sets raw interrupt bit i. The bit stays set until it is acknowledged.
- R8: The masked status at address 8 reads raw AND mask, where the mask is held at address 6. `irq_o` is the OR of the masked bits and follows a mask write from the next cycle.
- R9: A write to address 7 (acknowledge) clears each raw bit written as 1 and leaves the other bits alone. Address 7 reads 0.
- R10: When an expiry and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R11: A divisor write does not change the counter. The new value is taken at the next load operation or the next reload.
- R12: Reading address 3i+2 returns timer i's live count. Address 3i+1 returns its control word. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ext_tick_i | input | 1 | External tick strobe (source code 0) |
| tick_i | input | 4 | Tick strobes for source codes 4 to 7 |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is an expiry and an acknowledge of the same bit landing on the same clock edge. It needs the counter at exactly zero, in run mode, at the moment the bus write commits. The bench walks timer 1 with divisor 1 down to zero using single strobes. It then raises `tick_i[3]` and presents the acknowledge write in the same cycle, and reads back the masked status. A second hard case is the reload that follows a divisor change while the timer is running. It is reached by changing the divisor mid-count and then counting through the expiry.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int CTRL_W   = 5;
  localparam int TICK_SRC = 4;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmr_op_e;

  typedef struct packed {
    logic [2:0] src;
    tmr_op_e    op;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RST = '{src: 3'd1, op: OP_HOLD};
endpackage

// File: rtl/dtt_timer.sv
module dtt_timer
  import dtt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       div_we_i,
  input  logic                       ctrl_we_i,
  input  logic [CNT_W-1:0]           div_wdata_i,
  input  logic [CTRL_W-1:0]          ctrl_wdata_i,
  input  logic                       ext_tick_i,
  input  logic [TICK_SRC-1:0]        tick_i,
  output logic [CNT_W-1:0]           count_o,
  output logic [CNT_W-1:0]           div_o,
  output logic [CTRL_W-1:0]          ctrl_o,
  output logic [1:0]                 op_o,
  output logic                       expire_o
);
  tmr_ctrl_t        ctrl_q, ctrl_new;
  logic [CNT_W-1:0] div_q, count_q;
  logic             tick_sel, ctrl_ok, load_now;

  assign ctrl_new = tmr_ctrl_t'(ctrl_wdata_i);
  assign ctrl_ok  = ctrl_we_i && (ctrl_new.op != OP_BAD);
  assign load_now = ctrl_ok && (ctrl_new.op == OP_LOAD);

  always_comb begin
    case (ctrl_q.src)
      3'd0:                      tick_sel = ext_tick_i;
      3'd4, 3'd5, 3'd6, 3'd7:    tick_sel = tick_i[ctrl_q.src[1:0]];
      default:                   tick_sel = 1'b0;
    endcase
  end

  assign expire_o = (ctrl_q.op == OP_RUN) && tick_sel && (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      div_q   <= '0;
      count_q <= '0;
    end else begin
      if (ctrl_ok)  ctrl_q <= ctrl_new;
      if (div_we_i) div_q  <= div_wdata_i;
      if (load_now) begin
        count_q <= div_q;
      end else if ((ctrl_q.op == OP_RUN) && tick_sel) begin
        count_q <= (count_q == '0) ? div_q : count_q - 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign div_o   = div_q;
  assign ctrl_o  = ctrl_q;
  assign op_o    = ctrl_q.op;
endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
  parameter int N_TMR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic             ack_we_i,
  input  logic [N_TMR-1:0] wbits_i,
  input  logic [N_TMR-1:0] expire_i,
  output logic [N_TMR-1:0] raw_o,
  output logic [N_TMR-1:0] mask_o,
  output logic [N_TMR-1:0] status_o,
  output logic             irq_o
);
  logic [N_TMR-1:0] raw_q, mask_q, clr;

  assign clr = ack_we_i ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | expire_i;  // set beats clear
      if (mask_we_i) mask_q <= wbits_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign status_o = raw_q & mask_q;
  assign irq_o    = |status_o;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  localparam int N_REG  = 3 * N_TMR + 3,
  localparam int ADDR_W = $clog2(N_REG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                ext_tick_i,
  input  logic [TICK_SRC-1:0] tick_i,
  output logic                irq_o
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3 * N_TMR);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(3 * N_TMR + 1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3 * N_TMR + 2);

  logic                         wr;
  logic [N_TMR-1:0]             div_we, ctrl_we, expire_w;
  logic [N_TMR-1:0][CNT_W-1:0]  count_w, div_w;
  logic [N_TMR-1:0][CTRL_W-1:0] ctrl_w;
  logic [N_TMR-1:0][1:0]        op_w;
  logic [N_TMR-1:0]             raw_w, mask_w, status_w;
  logic                         mask_we, ack_we;

  assign wr      = req_i && we_i;
  assign mask_we = wr && (addr_i == A_MASK);
  assign ack_we  = wr && (addr_i == A_ACK);

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    assign div_we[i]  = wr && (addr_i == ADDR_W'(3 * i));
    assign ctrl_we[i] = wr && (addr_i == ADDR_W'(3 * i + 1));

    dtt_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .div_we_i     (div_we[i]),
      .ctrl_we_i    (ctrl_we[i]),
      .div_wdata_i  (wdata_i[CNT_W-1:0]),
      .ctrl_wdata_i (wdata_i[CTRL_W-1:0]),
      .ext_tick_i   (ext_tick_i),
      .tick_i       (tick_i),
      .count_o      (count_w[i]),
      .div_o        (div_w[i]),
      .ctrl_o       (ctrl_w[i]),
      .op_o         (op_w[i]),
      .expire_o     (expire_w[i])
    );
  end

  dtt_irq #(.N_TMR(N_TMR)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (mask_we),
    .ack_we_i  (ack_we),
    .wbits_i   (wdata_i[N_TMR-1:0]),
    .expire_i  (expire_w),
    .raw_o     (raw_w),
    .mask_o    (mask_w),
    .status_o  (status_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (addr_i == ADDR_W'(3 * i))     rdata_o = DATA_W'(div_w[i]);
      if (addr_i == ADDR_W'(3 * i + 1)) rdata_o = DATA_W'(ctrl_w[i]);
      if (addr_i == ADDR_W'(3 * i + 2)) rdata_o = DATA_W'(count_w[i]);
    end
    if (addr_i == A_MASK) rdata_o = DATA_W'(mask_w);
    if (addr_i == A_STAT) rdata_o = DATA_W'(status_w);
  end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int N_TMR = 2,
  parameter int CNT_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        irq_o,
  input logic [N_TMR-1:0]            wr_ctrl,
  input logic [N_TMR-1:0]            wr_div,
  input logic                        wr_ack,
  input logic                        wr_mask,
  input logic [1:0]                  w_op,
  input logic [N_TMR-1:0]            w_bits,
  input logic [N_TMR-1:0][1:0]       op,
  input logic [N_TMR-1:0][CNT_W-1:0] count,
  input logic [N_TMR-1:0][CNT_W-1:0] div,
  input logic [N_TMR-1:0]            expire,
  input logic [N_TMR-1:0]            raw
);
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask && (w_bits == '0) |=> !irq_o);  // R8

  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ack && w_bits[i] && !expire[i] |=> !raw[i]);  // R9
    AST_EXPIRY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[i] |=> raw[i]);  // R10
    AST_BAD_OP_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ctrl[i] && (w_op == 2'd3) |=> $stable(op[i]));  // R5
    AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op[i] == 2'd1) && !wr_ctrl[i] |=> $stable(count[i]));  // R3
    AST_DIV_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_div[i] && (op[i] != 2'd2) && !wr_ctrl[i] |=> $stable(count[i]));  // R11
    AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[i] && !wr_ctrl[i] |=> count[i] == $past(div[i]));  // R4
  end
endmodule

bind dual_tick_timer dtt_checker #(.N_TMR(N_TMR), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .wr_ctrl (ctrl_we),
  .wr_div  (div_we),
  .wr_ack  (ack_we),
  .wr_mask (mask_we),
  .w_op    (wdata_i[1:0]),
  .w_bits  (wdata_i[N_TMR-1:0]),
  .op      (op_w),
  .count   (count_w),
  .div     (div_w),
  .expire  (expire_w),
  .raw     (raw_w)
);

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ext_tick_i = 1'b0;
  logic [3:0]  tick_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dual_tick_timer dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i), .we_i (we_i),
    .addr_i (addr_i), .wdata_i (wdata_i), .rdata_o (rdata_o),
    .ext_tick_i (ext_tick_i), .tick_i (tick_i), .irq_o (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic pulse(input logic ext, input logic [3:0] t, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      ext_tick_i = ext; tick_i = t;
      @(negedge clk_i);
      ext_tick_i = 1'b0; tick_i = '0;
    end
  endtask

  task automatic t_reset;
    rd_chk(4'd1, 32'd5, "R1 ctrl0");
    rd_chk(4'd4, 32'd5, "R1 ctrl1");
    rd_chk(4'd2, 32'd0, "R1 count0");
    rd_chk(4'd6, 32'd0, "R1 mask");
    rd_chk(4'd8, 32'd0, "R1 status");
    check("R1 irq", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_load_hold;
    wr(4'd0, 32'd7);
    wr(4'd1, (32'd4 << 2) | 32'd0);
    rd_chk(4'd2, 32'd7, "R2 load copies divisor");
    pulse(1'b0, 4'b0001, 3);
    rd_chk(4'd2, 32'd7, "R2 load mode ignores ticks");
    wr(4'd1, (32'd4 << 2) | 32'd1);
    pulse(1'b0, 4'b0001, 2);
    rd_chk(4'd2, 32'd7, "R3 hold frozen");
    wr(4'd0, 32'd3);
    rd_chk(4'd2, 32'd7, "R11 divisor write leaves count");
  endtask

  task automatic t_run;
    wr(4'd1, (32'd4 << 2) | 32'd2);
    pulse(1'b0, 4'b0001, 1);
    rd_chk(4'd2, 32'd6, "R12 live count after one tick");
    pulse(1'b0, 4'b0001, 6);
    rd_chk(4'd2, 32'd0, "R4 reached zero");
    check("R7 no early irq", {31'd0, irq_o}, 32'd0);
    pulse(1'b0, 4'b0001, 1);
    rd_chk(4'd2, 32'd3, "R11 reload takes new divisor");
    check("R8 masked off", {31'd0, irq_o}, 32'd0);
    wr(4'd6, 32'd1);
    check("R8 irq after mask", {31'd0, irq_o}, 32'd1);
    rd_chk(4'd8, 32'd1, "R7 raw bit0 set");
    pulse(1'b0, 4'b0001, 4);
    rd_chk(4'd2, 32'd3, "R4 periodic reload");
  endtask

  task automatic t_source;
    pulse(1'b0, 4'b0010, 1);
    rd_chk(4'd2, 32'd3, "R6 unselected tick ignored");
    wr(4'd1, 32'd2);
    pulse(1'b1, 4'b0000, 1);
    rd_chk(4'd2, 32'd2, "R6 external source");
    wr(4'd1, (32'd1 << 2) | 32'd2);
    pulse(1'b1, 4'b1111, 2);
    rd_chk(4'd2, 32'd2, "R6 source 1 never ticks");
    wr(4'd1, (32'd5 << 2) | 32'd3);
    rd_chk(4'd1, 32'd6, "R5 bad op dropped");
    rd_chk(4'd2, 32'd2, "R5 count kept");
  endtask

  task automatic t_ack;
    rd_chk(4'd7, 32'd0, "R9 ack reads zero");
    wr(4'd7, 32'd1);
    rd_chk(4'd8, 32'd0, "R9 ack clears bit0");
    check("R9 irq drops", {31'd0, irq_o}, 32'd0);
    wr(4'd3, 32'd1);
    wr(4'd4, (32'd7 << 2) | 32'd2);
    pulse(1'b0, 4'b1000, 1);
    rd_chk(4'd5, 32'd1, "R4 timer1 expiry reload");
    wr(4'd6, 32'd3);
    rd_chk(4'd8, 32'd2, "R7 timer1 sets bit1");
    wr(4'd7, 32'd1);
    rd_chk(4'd8, 32'd2, "R9 other bit untouched");
    pulse(1'b0, 4'b1000, 1);
    rd_chk(4'd5, 32'd0, "R12 timer1 count");
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 4'd7; wdata_i = 32'd2; tick_i = 4'b1000;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; tick_i = '0;
    rd_chk(4'd8, 32'd2, "R10 expiry beats ack");
    check("R10 irq stays", {31'd0, irq_o}, 32'd1);
    wr(4'd7, 32'd2);
    rd_chk(4'd8, 32'd0, "R9 bit1 cleared");
    rd_chk(4'd9, 32'd0, "R12 unmapped reads zero");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_load_hold();
    t_run();
    t_source();
    t_ack();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule